// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Sequencer

This block puts a processor subsystem into one of three reduced-power states and later brings it back to full operation. It drives the enables for the core clock, the internal RC oscillator, the flash array and the logic regulator. It also raises a reset request when the deepest state is left, because that state keeps no register contents. On a wake event it counts the start-up delays before the core may run again. The length of that delay depends on the clock source that was selected when the low-power state was entered.

A separate flash timer runs alongside the resume delay. It counts RC-oscillator ticks once the oscillator is stable, so code running from SRAM can start before flash access is allowed. A low-power request that arrives while a wake-up is still counting is kept and acted on once the core runs again. The sequencer clock (`clk`) is the free-running main clock; one `clk` cycle is one main-oscillator cycle. `rcTick` is a single-cycle strobe, one per RC-oscillator cycle.

Top module: `lpwr_wake_seq`

## Requirements
- R1: After `rstN` is released, `coreRunEn`, `rcOscEn`, `flashEn`, `regulatorEn` and `flashReady` are 1 and `resetReq` is 0.
- R2: A one-cycle `lpReq` pulse while running enters the state coded on `lpMode`; from the next cycle `coreRunEn` is 0. `lpMode` codes: 1 is light sleep (oscillator, flash and regulator stay on); 2 is power-down (oscillator, flash and `flashReady` go to 0, regulator stays on); 3 is deep power-down (every enable, and `flashReady`, go to 0). Code 0 is ignored.
- R3: When light sleep was entered with `clkSelExt`=0 (RC source), `coreRunEn` rises in the cycle after the edge that samples the RC_RESUME_CYC-th `rcTick` following the wake edge.
- R4: With `clkSelExt`=1 at entry (external source), `coreRunEn` rises in the cycle after edge number EXT_RESUME_CYC counted from the wake edge. After power-down, that count starts at the end of the oscillator start-up (R6).
- R5: `clkSelExt` is captured at entry; changing it while in a low-power state has no effect on the resume delay.
- R6: A wake from power-down sets `rcOscEn` and `flashEn` to 1 in the next cycle. The block then waits ceil(OSC_START_NS*REF_CLK_KHZ/1e6) `clk` cycles for the oscillator, and ignores `rcTick` during that time. The resume delay of R3 or R4 follows.
- R7: After power-down, `flashReady` rises in the cycle after the edge that samples the FLASH_START_TICKS-th `rcTick` after the oscillator wait ends. With the RC source, `coreRunEn` is 1 before `flashReady` rises.
- R8: In deep power-down, `wakeIrq` is ignored. `rtcAlarm` or `extReset` raises `resetReq` for one cycle; in the cycle after that the outputs equal those of R1.
- R9: `extReset` in any state gives the same `resetReq` pulse and return to the R1 output state.
- R10: An `lpReq` with a nonzero code that arrives while not running is held. The held state is entered at the first edge where `coreRunEn` is 1, so `coreRunEn` is high for exactly one cycle. A reset exit (R8, R9) discards a held request.
- R11: In light sleep and power-down, a `wakeIrq` or `rtcAlarm` pulse starts the wake sequence. Without one, `coreRunEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock (main oscillator) |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| lpReq | input | 1 | One-cycle request to enter a low-power state |
| lpMode | input | 2 | Requested state: 1 sleep, 2 power-down, 3 deep power-down |
| clkSelExt | input | 1 | Current core clock source: 1 external oscillator, 0 RC oscillator |
| wakeIrq | input | 1 | Enabled interrupt wake event |
| rtcAlarm | input | 1 | RTC alarm wake event |
| extReset | input | 1 | External reset event |
| rcTick | input | 1 | One pulse per RC-oscillator cycle |
| rcOscEn | output | 1 | RC oscillator enable |
| flashEn | output | 1 | Flash power enable |
| regulatorEn | output | 1 | Internal logic regulator enable |
| coreRunEn | output | 1 | Core clock / code execution enable |
| flashReady | output | 1 | Flash access permitted |
| resetReq | output | 1 | Full-chip reset request |

## Verification
The hardest case to reach is a request that arrives inside the short resume window. It must be held, then fire at the first running edge, so that `coreRunEn` is high for exactly one cycle. The bench wakes the block from sleep with the RC source and issues a new sleep request on the very next cycle, while the tick count is still running. It then watches the single-cycle run pulse. A second hard case is a request held through deep power-down and dropped by the reset exit. The bench sets it up by requesting during deep power-down before sending the alarm.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_PDOWN = 2'd2,
    MODE_DEEP  = 2'd3
  } lpMode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_PDOWN,
    ST_DEEP,
    ST_OSCWAIT,
    ST_RESUME,
    ST_RSTREQ
  } seqState_e;

  typedef enum logic [1:0] {
    LIM_OSC,
    LIM_RC,
    LIM_EXT
  } limSel_e;

  typedef struct packed {
    logic    seqClr;
    logic    seqInc;
    limSel_e seqLim;
    logic    flashClr;
    logic    flashSet;
    logic    flashRun;
  } strobe_t;

endpackage

// File: rtl/lpwr_timers.sv
module lpwr_timers
  import lpwr_pkg::*;
#(
  parameter int RC_RESUME_CYC     = 4,
  parameter int EXT_RESUME_CYC    = 4096,
  parameter int FLASH_START_TICKS = 400,
  parameter int OSC_START_CYC     = 720
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    rcTick,
  output logic    seqDone,
  output logic    flashReady
);

  localparam int MAX_A   = (RC_RESUME_CYC > EXT_RESUME_CYC) ? RC_RESUME_CYC : EXT_RESUME_CYC;
  localparam int MAX_SEQ = (MAX_A > OSC_START_CYC) ? MAX_A : OSC_START_CYC;
  localparam int SEQ_W   = $clog2(MAX_SEQ + 1);
  localparam int FL_W    = $clog2(FLASH_START_TICKS + 1);

  logic [SEQ_W-1:0] seqCnt;
  logic [SEQ_W-1:0] seqLimit;
  logic [FL_W-1:0]  flashCnt;

  always_comb begin
    case (stb.seqLim)
      LIM_RC:  seqLimit = SEQ_W'(RC_RESUME_CYC);
      LIM_EXT: seqLimit = SEQ_W'(EXT_RESUME_CYC);
      default: seqLimit = SEQ_W'(OSC_START_CYC);
    endcase
  end

  assign seqDone = stb.seqInc && (seqCnt == seqLimit - SEQ_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCnt <= '0;
    end else if (stb.seqClr || seqDone) begin
      seqCnt <= '0;
    end else if (stb.seqInc) begin
      seqCnt <= seqCnt + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCnt   <= '0;
      flashReady <= 1'b1;
    end else if (stb.flashSet) begin
      flashCnt   <= '0;
      flashReady <= 1'b1;
    end else if (stb.flashClr) begin
      flashCnt   <= '0;
      flashReady <= 1'b0;
    end else if (stb.flashRun && rcTick && !flashReady) begin
      if (flashCnt == FL_W'(FLASH_START_TICKS - 1)) begin
        flashCnt   <= '0;
        flashReady <= 1'b1;
      end else begin
        flashCnt <= flashCnt + FL_W'(1);
      end
    end
  end

  assert_seq_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    seqCnt < SEQ_W'(MAX_SEQ));

  assert_flash_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    flashCnt < FL_W'(FLASH_START_TICKS));

  assert_flash_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashReady) |-> ($past(rcTick) && $past(stb.flashRun)) || $past(stb.flashSet));

endmodule

// File: rtl/lpwr_ctrl.sv
module lpwr_ctrl
  import lpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpReq,
  input  logic [1:0] lpMode,
  input  logic       clkSelExt,
  input  logic       wakeIrq,
  input  logic       rtcAlarm,
  input  logic       extReset,
  input  logic       rcTick,
  input  logic       seqDone,
  input  logic       flashReady,
  output strobe_t    stb,
  output logic       rcOscEn,
  output logic       flashEn,
  output logic       regulatorEn,
  output logic       coreRunEn,
  output logic       resetReq
);

  seqState_e st, stNext;
  logic      srcExt;
  logic      pendValid;
  lpMode_e   pendMode;
  logic      enterNow;
  lpMode_e   enterMode;
  logic      newReq;

  assign newReq = lpReq && (lpMode != 2'd0);

  always_comb begin
    stNext    = st;
    stb       = '0;
    enterNow  = 1'b0;
    enterMode = MODE_NONE;
    case (st)
      ST_RUN: begin
        stb.flashRun = 1'b1;
        if (newReq) begin
          enterNow  = 1'b1;
          enterMode = lpMode_e'(lpMode);
        end else if (pendValid) begin
          enterNow  = 1'b1;
          enterMode = pendMode;
        end
        if (enterNow) begin
          case (enterMode)
            MODE_SLEEP: stNext = ST_SLEEP;
            MODE_PDOWN: begin stNext = ST_PDOWN; stb.flashClr = 1'b1; end
            MODE_DEEP:  begin stNext = ST_DEEP;  stb.flashClr = 1'b1; end
            default:    stNext = ST_RUN;
          endcase
        end
      end
      ST_SLEEP: begin
        stb.flashRun = 1'b1;
        if (wakeIrq || rtcAlarm) begin
          stNext     = ST_RESUME;
          stb.seqClr = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (wakeIrq || rtcAlarm) begin
          stNext     = ST_OSCWAIT;
          stb.seqClr = 1'b1;
        end
      end
      ST_DEEP: begin
        if (rtcAlarm) stNext = ST_RSTREQ;
      end
      ST_OSCWAIT: begin
        stb.seqLim = LIM_OSC;
        stb.seqInc = 1'b1;
        if (seqDone) stNext = ST_RESUME;
      end
      ST_RESUME: begin
        stb.flashRun = 1'b1;
        stb.seqLim   = srcExt ? LIM_EXT : LIM_RC;
        stb.seqInc   = srcExt ? 1'b1 : rcTick;
        if (seqDone) stNext = ST_RUN;
      end
      ST_RSTREQ: begin
        stNext       = ST_RUN;
        stb.flashSet = 1'b1;
        stb.seqClr   = 1'b1;
      end
      default: stNext = ST_RUN;
    endcase
    if (extReset) stNext = ST_RSTREQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_RUN;
      srcExt    <= 1'b0;
      pendValid <= 1'b0;
      pendMode  <= MODE_NONE;
    end else begin
      st <= stNext;
      if (st == ST_RSTREQ) begin
        srcExt <= 1'b0;
      end else if (st == ST_RUN && enterNow) begin
        srcExt <= clkSelExt;
      end
      if (st == ST_RSTREQ || stNext == ST_RSTREQ) begin
        pendValid <= 1'b0;
        pendMode  <= MODE_NONE;
      end else if (st == ST_RUN && enterNow) begin
        pendValid <= 1'b0;
      end else if (st != ST_RUN && newReq) begin
        pendValid <= 1'b1;
        pendMode  <= lpMode_e'(lpMode);
      end
    end
  end

  always_comb begin
    coreRunEn   = 1'b0;
    rcOscEn     = 1'b1;
    flashEn     = 1'b1;
    regulatorEn = 1'b1;
    resetReq    = 1'b0;
    case (st)
      ST_RUN:    coreRunEn = 1'b1;
      ST_PDOWN:  begin rcOscEn = 1'b0; flashEn = 1'b0; end
      ST_DEEP:   begin rcOscEn = 1'b0; flashEn = 1'b0; regulatorEn = 1'b0; end
      ST_RSTREQ: resetReq = 1'b1;
      default:   ;
    endcase
  end

  assert_run_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRunEn) |-> ($past(st) == ST_RESUME || $past(st) == ST_RSTREQ));

  assert_src_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_RUN && st != ST_RSTREQ) |=> $stable(srcExt));

  assert_deep_ignores_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DEEP && !rtcAlarm && !extReset) |=> (st == ST_DEEP));

  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !extReset) |=> (!resetReq && coreRunEn && flashReady));

  assert_flash_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    flashReady |-> flashEn);

endmodule

// File: rtl/lpwr_wake_seq.sv
module lpwr_wake_seq
  import lpwr_pkg::*;
#(
  parameter int RC_RESUME_CYC     = 4,
  parameter int EXT_RESUME_CYC    = 4096,
  parameter int FLASH_START_TICKS = 400,
  parameter int REF_CLK_KHZ       = 12000,
  parameter int OSC_START_NS      = 60000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpReq,
  input  logic [1:0] lpMode,
  input  logic       clkSelExt,
  input  logic       wakeIrq,
  input  logic       rtcAlarm,
  input  logic       extReset,
  input  logic       rcTick,
  output logic       rcOscEn,
  output logic       flashEn,
  output logic       regulatorEn,
  output logic       coreRunEn,
  output logic       flashReady,
  output logic       resetReq
);

  localparam int OSC_RAW       = (OSC_START_NS * REF_CLK_KHZ + 999999) / 1000000;
  localparam int OSC_START_CYC = (OSC_RAW < 1) ? 1 : OSC_RAW;

  strobe_t stb;
  logic    seqDone;

  lpwr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lpReq      (lpReq),
    .lpMode     (lpMode),
    .clkSelExt  (clkSelExt),
    .wakeIrq    (wakeIrq),
    .rtcAlarm   (rtcAlarm),
    .extReset   (extReset),
    .rcTick     (rcTick),
    .seqDone    (seqDone),
    .flashReady (flashReady),
    .stb        (stb),
    .rcOscEn    (rcOscEn),
    .flashEn    (flashEn),
    .regulatorEn(regulatorEn),
    .coreRunEn  (coreRunEn),
    .resetReq   (resetReq)
  );

  lpwr_timers #(
    .RC_RESUME_CYC    (RC_RESUME_CYC),
    .EXT_RESUME_CYC   (EXT_RESUME_CYC),
    .FLASH_START_TICKS(FLASH_START_TICKS),
    .OSC_START_CYC    (OSC_START_CYC)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rcTick    (rcTick),
    .seqDone   (seqDone),
    .flashReady(flashReady)
  );

endmodule

// File: tb/sim_lpwr_wake_seq.sv
module sim_lpwr_wake_seq;

  localparam int RC_RES  = 4;
  localparam int EXT_RES = 32;
  localparam int FL_TK   = 10;
  localparam int REF_KHZ = 100;
  localparam int OSC_NS  = 60000;
  localparam int OSC_CYC = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lpReq = 1'b0;
  logic [1:0] lpMode = 2'd0;
  logic       clkSelExt = 1'b0;
  logic       wakeIrq = 1'b0;
  logic       rtcAlarm = 1'b0;
  logic       extReset = 1'b0;
  logic       rcTick = 1'b0;
  logic       rcOscEn, flashEn, regulatorEn, coreRunEn, flashReady, resetReq;

  int compared = 0;
  int mismatched = 0;
  int tickDiv = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 2) ? 0 : tickDiv + 1;
    rcTick  <= (tickDiv == 1);
  end

  lpwr_wake_seq #(
    .RC_RESUME_CYC(RC_RES), .EXT_RESUME_CYC(EXT_RES), .FLASH_START_TICKS(FL_TK),
    .REF_CLK_KHZ(REF_KHZ), .OSC_START_NS(OSC_NS)
  ) u0 (
    .clk(clk), .rstN(rstN), .lpReq(lpReq), .lpMode(lpMode), .clkSelExt(clkSelExt),
    .wakeIrq(wakeIrq), .rtcAlarm(rtcAlarm), .extReset(extReset), .rcTick(rcTick),
    .rcOscEn(rcOscEn), .flashEn(flashEn), .regulatorEn(regulatorEn),
    .coreRunEn(coreRunEn), .flashReady(flashReady), .resetReq(resetReq)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic request(input logic [1:0] m, input logic ext);
    clkSelExt = ext;
    lpMode = m;
    lpReq = 1'b1;
    @(posedge clk); #1;
    lpReq = 1'b0;
    lpMode = 2'd0;
  endtask

  task automatic pulseEv(input int which);
    if (which == 0) wakeIrq = 1'b1;
    else if (which == 1) rtcAlarm = 1'b1;
    else extReset = 1'b1;
    @(posedge clk); #1;
    wakeIrq = 1'b0; rtcAlarm = 1'b0; extReset = 1'b0;
  endtask

  task automatic resetValues(input string tag);
    chkEq({tag, " coreRunEn"}, coreRunEn, 1);
    chkEq({tag, " rcOscEn"}, rcOscEn, 1);
    chkEq({tag, " flashEn"}, flashEn, 1);
    chkEq({tag, " regulatorEn"}, regulatorEn, 1);
    chkEq({tag, " flashReady"}, flashReady, 1);
    chkEq({tag, " resetReq"}, resetReq, 0);
  endtask

  task automatic measure(input int skip, output int runEdge, output int runTicks,
                         output int runLast, output int flEdge, output int flTicks,
                         output int flLast);
    int tk = 0;
    bit runSeen = 0;
    bit flSeen = 0;
    logic t;
    runEdge = 0; runTicks = 0; runLast = 0; flEdge = 0; flTicks = 0; flLast = 0;
    for (int i = 1; i < 2000; i++) begin
      @(posedge clk);
      t = rcTick;
      #1;
      if (i > skip && t) tk++;
      if (!runSeen && coreRunEn) begin
        runSeen = 1; runEdge = i; runTicks = tk; runLast = (i > skip) ? int'(t) : 0;
      end
      if (!flSeen && flashReady) begin
        flSeen = 1; flEdge = i; flTicks = tk; flLast = (i > skip) ? int'(t) : 0;
      end
      if (runSeen && flSeen) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int runEdge, runTicks, runLast, flEdge, flTicks, flLast, skip;
    idle(3);
    rstN = 1'b1;
    idle(2);
    resetValues("R1");

    // Code 0 request is ignored
    request(2'd0, 1'b0);
    idle(2);
    chkEq("R2 code0 coreRunEn", coreRunEn, 1);

    for (int ext = 0; ext < 2; ext++) begin
      for (int m = 1; m <= 2; m++) begin
        request(m[1:0], ext[0]);
        chkEq("R2 coreRunEn", coreRunEn, 0);
        chkEq("R2 rcOscEn", rcOscEn, (m == 1) ? 1 : 0);
        chkEq("R2 flashEn", flashEn, (m == 1) ? 1 : 0);
        chkEq("R2 flashReady", flashReady, (m == 1) ? 1 : 0);
        chkEq("R2 regulatorEn", regulatorEn, 1);
        clkSelExt = ~ext[0];
        idle(5);
        chkEq("R11 stays asleep", coreRunEn, 0);
        pulseEv(ext);
        skip = (m == 2) ? OSC_CYC : 0;
        if (m == 2) begin
          chkEq("R6 rcOscEn after wake", rcOscEn, 1);
          chkEq("R6 flashEn after wake", flashEn, 1);
        end
        measure(skip, runEdge, runTicks, runLast, flEdge, flTicks, flLast);
        if (ext == 1) begin
          chkEq("R4 ext resume edges", runEdge, skip + EXT_RES);
          chkEq("R5 latched ext source", runEdge, skip + EXT_RES);
        end else begin
          chkEq("R3 rc resume ticks", runTicks, RC_RES);
          chkEq("R3 last edge ticked", runLast, 1);
          chkEq("R5 latched rc source", runTicks, RC_RES);
          if (m == 2) chkEq("R6 oscillator wait", int'(runEdge > OSC_CYC), 1);
        end
        if (m == 2) begin
          chkEq("R7 flash ticks", flTicks, FL_TK);
          chkEq("R7 flash last edge ticked", flLast, 1);
          if (ext == 0) chkEq("R7 core before flash", int'(runEdge < flEdge), 1);
        end
        clkSelExt = 1'b0;
        idle(2);
        chkEq("R11 running again", coreRunEn, 1);
      end
    end

    // Held request during resume
    request(2'd1, 1'b0);
    pulseEv(0);
    request(2'd1, 1'b0);
    chkEq("R10 still resuming", coreRunEn, 0);
    measure(0, runEdge, runTicks, runLast, flEdge, flTicks, flLast);
    chkEq("R10 run reached", coreRunEn, 1);
    idle(1);
    chkEq("R10 single-cycle run", coreRunEn, 0);
    chkEq("R10 back in sleep rcOscEn", rcOscEn, 1);
    chkEq("R10 back in sleep regulatorEn", regulatorEn, 1);
    pulseEv(1);
    measure(0, runEdge, runTicks, runLast, flEdge, flTicks, flLast);
    idle(3);
    chkEq("R10 held request consumed", coreRunEn, 1);

    // Deep power-down, alarm exit
    request(2'd3, 1'b1);
    chkEq("R2 deep regulatorEn", regulatorEn, 0);
    chkEq("R2 deep rcOscEn", rcOscEn, 0);
    chkEq("R2 deep flashEn", flashEn, 0);
    chkEq("R2 deep flashReady", flashReady, 0);
    pulseEv(0);
    idle(4);
    chkEq("R8 irq ignored coreRunEn", coreRunEn, 0);
    chkEq("R8 irq ignored regulatorEn", regulatorEn, 0);
    request(2'd1, 1'b0);
    chkEq("R8 request during deep", regulatorEn, 0);
    pulseEv(1);
    chkEq("R8 resetReq pulse", resetReq, 1);
    chkEq("R8 core held", coreRunEn, 0);
    idle(1);
    resetValues("R8");
    idle(4);
    chkEq("R10 held request discarded", coreRunEn, 1);

    // Deep power-down, external reset exit
    request(2'd3, 1'b0);
    pulseEv(2);
    chkEq("R8 ext reset resetReq", resetReq, 1);
    idle(1);
    resetValues("R8 ext");

    // External reset from power-down and from run
    request(2'd2, 1'b0);
    pulseEv(2);
    chkEq("R9 resetReq from pdown", resetReq, 1);
    idle(1);
    resetValues("R9 pdown");
    pulseEv(2);
    chkEq("R9 resetReq from run", resetReq, 1);
    idle(1);
    resetValues("R9 run");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule